// File: doc/BRIEF.md
# Memory Error Logging Register Block

This block sits beside an ECC-protected memory and records the error events that the memory's checker reports. Each event arrives as a one-cycle pulse, either correctable or uncorrectable. With it come the faulting address and a bit that tells whether a CPU read or a DMA read caused it. The block keeps sticky status flags for each error class and remembers the last faulting address of each class. For correctable errors it also keeps a saturating event counter that is gated by a programmable threshold. Software reads this state and clears it through a small word-addressed register bus.

An uncorrectable error also sets a flag in a separate non-maskable interrupt flag register. The `nmi_req` output stays high for as long as that flag is set. A correctable event that brings the counter to or past the threshold produces a one-cycle pulse on `thr_irq`. The counter advances only while the threshold is nonzero. This lets software arm counting simply by programming the limit.

The register bus never applies back-pressure. A request is accepted in every cycle in which `reg_valid` is high. A read returns its data on `rsp_data`, with `rsp_valid` high, exactly one cycle later. A write produces no response. Control pins (`thr_irq`, `nmi_req`) are plain levels or pulses.

Top module: `mel_err_log`

## Requirements
- R1: After reset every register reads 0, and `thr_irq` and `nmi_req` are low.
- R2: A correctable event sets bit 0 (CPU read) of the correctable flag register (offset 0) when `evt_dma` is 0, or bit 1 (DMA read) when `evt_dma` is 1. The other bit keeps its value.
- R3: An uncorrectable event sets bit 0 (CPU read) or bit 1 (DMA read) of the uncorrectable flag register (offset 5) in the same way.
- R4: A write to a clear register (offset 1 for correctable, 6 for uncorrectable, 9 for NMI) clears each flag whose bit is 1 in the written data and leaves the others unchanged. If an event and a clear of the same flag arrive in the same cycle, the flag stays set.
- R5: The correctable address register (offset 2) and the uncorrectable address register (offset 7) load `evt_addr` on every event of their own class, so the last event wins. Clear writes do not change them.
- R6: The correctable counter (offset 3, `CNT_W` bits, default 32) increments by one on each correctable event only while the threshold register (offset 4) is nonzero. With a threshold of 0 it does not change.
- R7: The counter saturates at all ones and does not wrap.
- R8: `thr_irq` is high for exactly the one cycle after each correctable event that leaves the counter at or above a nonzero threshold. Otherwise it stays low.
- R9: An uncorrectable event sets bit 0 of the NMI flag register (offset 8). `nmi_req` is high while that bit is set. Only a write of bit 0 to offset 9 clears it; clearing the uncorrectable flags does not.
- R10: A read returns data one cycle after the request. Unmapped offsets read 0. Writes to the flag, address and counter registers are ignored. The threshold register reads back what was written.
- R11: A correctable and an uncorrectable event in the same cycle are both logged, and both address registers capture `evt_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_evt | input | 1 | Correctable error pulse |
| ue_evt | input | 1 | Uncorrectable error pulse |
| evt_dma | input | 1 | Event source: 0 CPU read, 1 DMA read |
| evt_addr | input | AW | Faulting address |
| reg_valid | input | 1 | Register request valid (always accepted) |
| reg_write | input | 1 | 1 write, 0 read |
| reg_offset | input | 4 | Word offset of the register |
| reg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |
| thr_irq | output | 1 | Threshold reached pulse |
| nmi_req | output | 1 | Non-maskable interrupt request level |

## Verification
An event pulse that is sampled on one rising edge updates flags, addresses, the counter, `thr_irq` and `nmi_req` on that same edge. A read request that is sampled on the next edge returns that state on `rsp_data` one edge later. The bench drives every input at a falling edge. It samples `thr_irq` at the falling edge right after the event edge, and samples it again one cycle later to confirm the pulse is one cycle long. It samples read data at the falling edge that follows the read's accepting edge. The event-versus-clear case drives both stimuli in one cycle and reads the flag back.

// File: rtl/mel_pkg.sv
package mel_pkg;
  localparam int OFS_W  = 4;
  localparam int DATA_W = 32;
  localparam int NSRC   = 2;
  localparam int SRC_CPU = 0;
  localparam int SRC_DMA = 1;

  typedef enum logic [OFS_W-1:0] {
    RA_CE_FLG  = 4'd0,
    RA_CE_CLR  = 4'd1,
    RA_CE_ADR  = 4'd2,
    RA_CE_CNT  = 4'd3,
    RA_CE_THR  = 4'd4,
    RA_UE_FLG  = 4'd5,
    RA_UE_CLR  = 4'd6,
    RA_UE_ADR  = 4'd7,
    RA_NMI_FLG = 4'd8,
    RA_NMI_CLR = 4'd9
  } reg_ofs_e;
endpackage

// File: rtl/mel_flag_bank.sv
module mel_flag_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)                   q <= 1'b0;
      else if (set_vec[i])          q <= 1'b1;   // event beats clear
      else if (clr_wr && clr_vec[i]) q <= 1'b0;
    end
    assign flags[i] = q;
  end
endmodule

// File: rtl/mel_addr_cap.sv
module mel_addr_cap #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= addr_in;
  end
endmodule

// File: rtl/mel_ce_counter.sv
module mel_ce_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          thr_wr,
  input  logic [CW-1:0] thr_wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] thr,
  output logic          irq
);
  logic          armed;
  logic          inc;
  logic          at_max;
  logic [CW-1:0] cnt_nx;

  always_comb begin
    armed  = (thr != '0);
    inc    = evt && armed;
    at_max = &cnt;
    cnt_nx = (inc && !at_max) ? cnt + 1'b1 : cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      thr <= '0;
      irq <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      irq <= inc && (cnt_nx >= thr);
      if (thr_wr) thr <= thr_wdata;
    end
  end
endmodule

// File: rtl/mel_regif.sv
module mel_regif
  import mel_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [OFS_W-1:0]  reg_offset,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NSRC-1:0]   ce_flg,
  input  logic [AW-1:0]     ce_adr,
  input  logic [CW-1:0]     ce_cnt,
  input  logic [CW-1:0]     ce_thr,
  input  logic [NSRC-1:0]   ue_flg,
  input  logic [AW-1:0]     ue_adr,
  input  logic              nmi_flg,
  output logic              ce_clr_wr,
  output logic              ue_clr_wr,
  output logic              nmi_clr_wr,
  output logic              thr_wr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic              wr_hit;
  logic              rd_hit;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    wr_hit     = reg_valid && reg_write;
    rd_hit     = reg_valid && !reg_write;
    ce_clr_wr  = wr_hit && (reg_offset == RA_CE_CLR);
    ue_clr_wr  = wr_hit && (reg_offset == RA_UE_CLR);
    nmi_clr_wr = wr_hit && (reg_offset == RA_NMI_CLR);
    thr_wr     = wr_hit && (reg_offset == RA_CE_THR);
  end

  always_comb begin
    rd_mux = '0;
    case (reg_offset)
      RA_CE_FLG:  rd_mux[NSRC-1:0] = ce_flg;
      RA_CE_ADR:  rd_mux[AW-1:0]   = ce_adr;
      RA_CE_CNT:  rd_mux[CW-1:0]   = ce_cnt;
      RA_CE_THR:  rd_mux[CW-1:0]   = ce_thr;
      RA_UE_FLG:  rd_mux[NSRC-1:0] = ue_flg;
      RA_UE_ADR:  rd_mux[AW-1:0]   = ue_adr;
      RA_NMI_FLG: rd_mux[0]        = nmi_flg;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_hit;
      if (rd_hit) rsp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/mel_err_log.sv
module mel_err_log
  import mel_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic              evt_dma,
  input  logic [AW-1:0]     evt_addr,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [OFS_W-1:0]  reg_offset,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              thr_irq,
  output logic              nmi_req
);
  logic [NSRC-1:0] ce_set, ue_set;
  logic [NSRC-1:0] ce_flg, ue_flg;
  logic [0:0]      nmi_flg;
  logic [AW-1:0]   ce_adr, ue_adr;
  logic [CW-1:0]   ce_cnt, ce_thr;
  logic            ce_clr_wr, ue_clr_wr, nmi_clr_wr, thr_wr;

  always_comb begin
    ce_set          = '0;
    ue_set          = '0;
    ce_set[SRC_CPU] = ce_evt && !evt_dma;
    ce_set[SRC_DMA] = ce_evt &&  evt_dma;
    ue_set[SRC_CPU] = ue_evt && !evt_dma;
    ue_set[SRC_DMA] = ue_evt &&  evt_dma;
  end

  mel_flag_bank #(.N(NSRC)) u_ce_flg (
    .clk(clk), .rst_n(rst_n), .set_vec(ce_set), .clr_wr(ce_clr_wr),
    .clr_vec(reg_wdata[NSRC-1:0]), .flags(ce_flg));

  mel_flag_bank #(.N(NSRC)) u_ue_flg (
    .clk(clk), .rst_n(rst_n), .set_vec(ue_set), .clr_wr(ue_clr_wr),
    .clr_vec(reg_wdata[NSRC-1:0]), .flags(ue_flg));

  mel_flag_bank #(.N(1)) u_nmi_flg (
    .clk(clk), .rst_n(rst_n), .set_vec(ue_evt), .clr_wr(nmi_clr_wr),
    .clr_vec(reg_wdata[0]), .flags(nmi_flg));

  mel_addr_cap #(.AW(AW)) u_ce_adr (
    .clk(clk), .rst_n(rst_n), .load(ce_evt), .addr_in(evt_addr), .addr_q(ce_adr));

  mel_addr_cap #(.AW(AW)) u_ue_adr (
    .clk(clk), .rst_n(rst_n), .load(ue_evt), .addr_in(evt_addr), .addr_q(ue_adr));

  mel_ce_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .evt(ce_evt), .thr_wr(thr_wr),
    .thr_wdata(reg_wdata[CW-1:0]), .cnt(ce_cnt), .thr(ce_thr), .irq(thr_irq));

  mel_regif #(.AW(AW), .CW(CW)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_offset(reg_offset), .reg_wdata(reg_wdata),
    .ce_flg(ce_flg), .ce_adr(ce_adr), .ce_cnt(ce_cnt), .ce_thr(ce_thr),
    .ue_flg(ue_flg), .ue_adr(ue_adr), .nmi_flg(nmi_flg[0]),
    .ce_clr_wr(ce_clr_wr), .ue_clr_wr(ue_clr_wr), .nmi_clr_wr(nmi_clr_wr),
    .thr_wr(thr_wr), .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  assign nmi_req = nmi_flg[0];
endmodule

module mel_err_log_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_evt,
  input logic          ue_evt,
  input logic          evt_dma,
  input logic          reg_valid,
  input logic          reg_write,
  input logic          rsp_valid,
  input logic          thr_irq,
  input logic          nmi_req,
  input logic [1:0]    ce_flg,
  input logic [1:0]    ue_flg,
  input logic [CW-1:0] ce_cnt,
  input logic [CW-1:0] ce_thr
);
  a_r2_ce_cpu_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && !evt_dma) |=> ce_flg[0]);
  a_r2_ce_dma_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && evt_dma) |=> ce_flg[1]);
  a_r3_ue_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && !evt_dma) |=> ue_flg[0]);
  a_r6_frozen_at_zero_thr: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_thr == '0) |=> $stable(ce_cnt));
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (&ce_cnt) |=> (&ce_cnt));
  a_r8_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    thr_irq |-> $past(ce_evt));
  a_r8_no_irq_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && ce_thr == '0) |=> !thr_irq);
  a_r9_nmi_raised: assert property (@(posedge clk) disable iff (!rst_n)
    ue_evt |=> nmi_req);
  a_r10_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write) |=> rsp_valid);
  a_r10_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write) |=> !rsp_valid);
endmodule

bind mel_err_log mel_err_log_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt), .evt_dma(evt_dma),
  .reg_valid(reg_valid), .reg_write(reg_write), .rsp_valid(rsp_valid),
  .thr_irq(thr_irq), .nmi_req(nmi_req), .ce_flg(ce_flg), .ue_flg(ue_flg),
  .ce_cnt(ce_cnt), .ce_thr(ce_thr));

// File: tb/tb_mel_err_log.sv
module tb_mel_err_log;
  localparam int AW = 16;
  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_evt = 1'b0, ue_evt = 1'b0, evt_dma = 1'b0;
  logic [AW-1:0] evt_addr = '0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [3:0]  reg_offset = '0;
  logic [31:0] reg_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        thr_irq, nmi_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mel_err_log #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt), .evt_dma(evt_dma),
    .evt_addr(evt_addr), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_offset(reg_offset), .reg_wdata(reg_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .thr_irq(thr_irq), .nmi_req(nmi_req));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rd(input logic [3:0] ofs, output logic [31:0] val);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_offset = ofs;
    @(negedge clk);
    reg_valid = 1'b0;
    check("R10 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    val = rsp_data;
  endtask

  task automatic wr(input logic [3:0] ofs, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_offset = ofs; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] ofs, input logic [31:0] exp);
    logic [31:0] v;
    rd(ofs, v);
    check(req, v, exp);
  endtask

  // pulse events; irq_seen is thr_irq in the cycle after the event edge
  task automatic pulse(input bit ce, input bit ue, input bit dma,
                       input logic [AW-1:0] a, output bit irq_seen);
    @(negedge clk);
    ce_evt = ce; ue_evt = ue; evt_dma = dma; evt_addr = a;
    @(negedge clk);
    irq_seen = thr_irq;
    ce_evt = 1'b0; ue_evt = 1'b0; evt_dma = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    for (int o = 0; o < 10; o++) expect_reg("R1 reg after reset", o[3:0], 32'd0);
    check("R1 nmi_req", {31'd0, nmi_req}, 32'd0);
    check("R1 thr_irq", {31'd0, thr_irq}, 32'd0);
  endtask

  task automatic t_ce_flags();
    bit s;
    pulse(1, 0, 0, 16'h1234, s);
    expect_reg("R2 ce cpu bit", 4'd0, 32'd1);
    expect_reg("R5 ce addr", 4'd2, 32'h1234);
    expect_reg("R2 ue untouched", 4'd5, 32'd0);
    pulse(1, 0, 1, 16'h0abc, s);
    expect_reg("R2 ce dma bit", 4'd0, 32'd3);
    expect_reg("R5 ce addr last wins", 4'd2, 32'h0abc);
  endtask

  task automatic t_clear();
    wr(4'd1, 32'd1);
    expect_reg("R4 clear cpu bit", 4'd0, 32'd2);
    wr(4'd1, 32'd2);
    expect_reg("R4 clear dma bit", 4'd0, 32'd0);
    expect_reg("R5 addr kept after clear", 4'd2, 32'h0abc);
  endtask

  task automatic t_ue_nmi();
    bit s;
    pulse(0, 1, 0, 16'h0777, s);
    expect_reg("R3 ue cpu bit", 4'd5, 32'd1);
    expect_reg("R5 ue addr", 4'd7, 32'h0777);
    expect_reg("R5 ce addr separate", 4'd2, 32'h0abc);
    expect_reg("R9 nmi flag", 4'd8, 32'd1);
    check("R9 nmi_req high", {31'd0, nmi_req}, 32'd1);
    wr(4'd6, 32'd1);
    expect_reg("R4 ue cleared", 4'd5, 32'd0);
    check("R9 nmi_req held", {31'd0, nmi_req}, 32'd1);
    wr(4'd9, 32'd1);
    expect_reg("R9 nmi flag cleared", 4'd8, 32'd0);
    check("R9 nmi_req low", {31'd0, nmi_req}, 32'd0);
    pulse(0, 1, 1, 16'h0778, s);
    expect_reg("R3 ue dma bit", 4'd5, 32'd2);
  endtask

  task automatic t_evt_vs_clr();
    @(negedge clk);
    ce_evt = 1'b1; evt_dma = 1'b0; evt_addr = 16'h0042;
    reg_valid = 1'b1; reg_write = 1'b1; reg_offset = 4'd1; reg_wdata = 32'd1;
    @(negedge clk);
    ce_evt = 1'b0; reg_valid = 1'b0; reg_write = 1'b0;
    expect_reg("R4 event beats clear", 4'd0, 32'd1);
  endtask

  task automatic t_thr_zero();
    bit s;
    bit any = 1'b0;
    do_reset();
    for (int i = 0; i < 3; i++) begin
      pulse(1, 0, 0, 16'h0010, s);
      any |= s;
    end
    expect_reg("R6 count frozen at zero thr", 4'd3, 32'd0);
    check("R8 no irq unarmed", {31'd0, any}, 32'd0);
  endtask

  task automatic t_thr_count();
    bit s;
    wr(4'd4, 32'd3);
    expect_reg("R10 thr readback", 4'd4, 32'd3);
    for (int i = 1; i <= 5; i++) begin
      pulse(1, 0, 0, 16'h0020, s);
      check("R8 irq pulse", {31'd0, s}, (i >= 3) ? 32'd1 : 32'd0);
      @(negedge clk);
      check("R8 irq one cycle", {31'd0, thr_irq}, 32'd0);
    end
    expect_reg("R6 count", 4'd3, 32'd5);
  endtask

  task automatic t_saturate();
    bit s;
    for (int i = 0; i < 12; i++) pulse(1, 0, 0, 16'h0030, s);
    expect_reg("R7 count saturated", 4'd3, 32'd15);
  endtask

  task automatic t_ro();
    wr(4'd3, 32'd9);
    expect_reg("R10 count write ignored", 4'd3, 32'd15);
    wr(4'd2, 32'h5555);
    expect_reg("R10 addr write ignored", 4'd2, 32'h0030);
    wr(4'd0, 32'd0);
    expect_reg("R10 flag write ignored", 4'd0, 32'd1);
    expect_reg("R10 unmapped reads 0", 4'd12, 32'd0);
  endtask

  task automatic t_both();
    bit s;
    do_reset();
    pulse(1, 1, 0, 16'h0055, s);
    expect_reg("R11 ce flag", 4'd0, 32'd1);
    expect_reg("R11 ue flag", 4'd5, 32'd1);
    expect_reg("R11 ce addr", 4'd2, 32'h0055);
    expect_reg("R11 ue addr", 4'd7, 32'h0055);
  endtask

  initial begin
    t_reset();
    t_ce_flags();
    t_clear();
    t_ue_nmi();
    t_evt_vs_clr();
    t_thr_zero();
    t_thr_count();
    t_saturate();
    t_ro();
    t_both();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule